// File: doc/BRIEF.md
# Column-Loaded Sliding Window Buffer

This block keeps a square window of 8-bit pixels, WIN columns by WIN rows, and exposes every pixel at once on a wide parallel bus for a downstream processing array. The window moves in whole-column steps. Each accepted strobe brings in a complete column of WIN bytes at the right-hand edge of the window. Every stored column moves one position to the left, and the leftmost column is dropped. As a result, the complete window is refreshed once per column period.

A larger image is covered by rastering. An upstream source sends IMG_W columns for each row position of the window. The window then steps down one pixel row, and the next pass across the image begins. There are IMG_H - WIN + 1 row positions in a frame. The block counts its own raster position and reports the origin of the window, which is the image coordinate of its top-left pixel. It also reports whether the window currently holds WIN columns from the same row pass, and it gives a one-cycle pulse when the last window of a frame has been presented.

Top module: `colWinBuf`

## Requirements
- R1: A synchronous active-high reset clears windowValid, originCol, originRow and frameEnd to 0 and restarts the raster at column 0 of row position 0. Reset does not clear the pixel contents.
- R2: Each cycle with colValid high shifts the window by one column. Window column k takes the previous column k+1, and column WIN-1 takes colData. Window column k appears at windowOut bits [k*WIN*8 +: WIN*8], and pixel row r of a column appears at bits [r*8 +: 8] inside it. The new contents appear on the outputs in the cycle after the load edge.
- R3: windowValid stays low after each of the first WIN-1 loads of a row pass. It goes high with the WIN-th load and stays high for the rest of that pass.
- R4: While windowValid is high, originCol equals the number of loads in the current row pass minus WIN, which is the image column of the leftmost window column. originRow equals the current row position. While windowValid is low, originCol reads 0.
- R5: In a cycle with colValid low, the window contents, windowValid, originCol and originRow all hold their values, whatever is on colData.
- R6: After IMG_W loads in a row pass, the next load starts a new pass one row lower. windowValid drops, originRow increases by one, and the fill count starts again.
- R7: frameEnd is high for exactly one cycle, in the cycle after the last load of the last row position (originRow = IMG_H-WIN, originCol = IMG_W-WIN). It is low at all other times.
- R8: After a frame ends, the next load starts again at row position 0 and column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| colValid | input | 1 | Column load strobe |
| colData | input | WIN*8 | Incoming column, pixel row r at bits [r*8 +: 8] |
| windowOut | output | WIN*WIN*8 | Whole window, column k at bits [k*WIN*8 +: WIN*8] |
| windowValid | output | 1 | Window holds WIN columns from the current row pass |
| originCol | output | $clog2(IMG_W) | Image column of the leftmost window column |
| originRow | output | max(1,$clog2(IMG_H-WIN+1)) | Row position of the window top |
| frameEnd | output | 1 | One-cycle pulse after the final window of a frame |

## Verification
The bench builds the block with WIN = 4, IMG_W = 8 and IMG_H = 6, which gives eight loads per row pass and three row positions per frame. With this size, a complete frame takes only 24 loads. The fill qualification, the row wrap, the frame-end pulse and the return to the first row can therefore all be checked against every pixel of a 128-bit window. The loads are sent both back-to-back and with idle gaps, and colData changes during the idle cycles. A reset is also applied partway through a row pass.

// File: rtl/colWinPkg.sv
package colWinPkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shift;   // move window one column and accept a new column
  } winStrobe_t;

endpackage

// File: rtl/colWinCtrl.sv
module colWinCtrl
  import colWinPkg::*;
#(
  parameter int WIN   = 64,
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  localparam int ROWS  = IMG_H - WIN + 1,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             colValid,
  output winStrobe_t       strobe,
  output logic             windowValid,
  output logic [COL_W-1:0] originCol,
  output logic [ROW_W-1:0] originRow,
  output logic             frameEnd
);

  // index of the column about to be loaded within the current row pass
  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic lastCol, lastRow, fillDone;

  always_comb begin
    lastCol  = (colCnt == COL_W'(IMG_W - 1));
    lastRow  = (rowCnt == ROW_W'(ROWS - 1));
    fillDone = (colCnt >= COL_W'(WIN - 1));
    strobe.shift = colValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt      <= '0;
      rowCnt      <= '0;
      windowValid <= 1'b0;
      originCol   <= '0;
      originRow   <= '0;
      frameEnd    <= 1'b0;
    end else begin
      frameEnd <= 1'b0;
      if (colValid) begin
        windowValid <= fillDone;
        originCol   <= fillDone ? (colCnt - COL_W'(WIN - 1)) : '0;
        originRow   <= rowCnt;
        frameEnd    <= lastCol && lastRow;
        if (lastCol) begin
          colCnt <= '0;
          rowCnt <= lastRow ? '0 : (rowCnt + ROW_W'(1));
        end else begin
          colCnt <= colCnt + COL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/colWinData.sv
module colWinData
  import colWinPkg::*;
#(
  parameter int WIN   = 64,
  parameter int PIX_W = 8,
  localparam int COLB = WIN * PIX_W,
  localparam int TOTB = WIN * COLB
) (
  input  logic            clk,
  input  winStrobe_t      strobe,
  input  logic [COLB-1:0] colData,
  output logic [TOTB-1:0] windowOut
);

  // one register per window column; column WIN-1 is the newest
  for (genvar k = 0; k < WIN; k++) begin : colGen
    logic [COLB-1:0] colReg;
    if (k == WIN - 1) begin : newest
      always_ff @(posedge clk) begin
        if (strobe.shift) colReg <= colData;
      end
    end else begin : older
      always_ff @(posedge clk) begin
        if (strobe.shift) colReg <= colGen[k+1].colReg;
      end
    end
    assign windowOut[k*COLB +: COLB] = colReg;
  end

endmodule

// File: rtl/colWinBuf.sv
module colWinBuf
  import colWinPkg::*;
#(
  parameter int WIN   = 64,
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 8,
  localparam int ROWS  = IMG_H - WIN + 1,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COLB  = WIN * PIX_W,
  localparam int TOTB  = WIN * COLB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             colValid,
  input  logic [COLB-1:0]  colData,
  output logic [TOTB-1:0]  windowOut,
  output logic             windowValid,
  output logic [COL_W-1:0] originCol,
  output logic [ROW_W-1:0] originRow,
  output logic             frameEnd
);

  winStrobe_t strobe;

  colWinCtrl #(.WIN(WIN), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .colValid   (colValid),
    .strobe     (strobe),
    .windowValid(windowValid),
    .originCol  (originCol),
    .originRow  (originRow),
    .frameEnd   (frameEnd)
  );

  colWinData #(.WIN(WIN), .PIX_W(PIX_W)) u_data (
    .clk      (clk),
    .strobe   (strobe),
    .colData  (colData),
    .windowOut(windowOut)
  );

endmodule

// File: rtl/colWinBuf_chk.sv
module colWinBuf_chk #(
  parameter int WIN   = 64,
  parameter int IMG_W = 256,
  parameter int IMG_H = 256,
  parameter int PIX_W = 8,
  localparam int ROWS  = IMG_H - WIN + 1,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COLB  = WIN * PIX_W,
  localparam int TOTB  = WIN * COLB
) (
  input logic             clk,
  input logic             rst,
  input logic             colValid,
  input logic [COLB-1:0]  colData,
  input logic [TOTB-1:0]  windowOut,
  input logic             windowValid,
  input logic [COL_W-1:0] originCol,
  input logic [ROW_W-1:0] originRow,
  input logic             frameEnd
);

  AST_NEW_COLUMN: assert property (@(posedge clk) disable iff (rst)
    colValid |=> windowOut[TOTB-1 -: COLB] == $past(colData)); // R2

  AST_COLUMN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    colValid |=> windowOut[TOTB-COLB-1:0] == $past(windowOut[TOTB-1:COLB])); // R2

  AST_ORIGIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    windowValid |-> originCol <= COL_W'(IMG_W - WIN)); // R4

  AST_ORIGIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !windowValid |-> originCol == '0); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !colValid |=> $stable(windowOut) && $stable(windowValid)
                  && $stable(originCol) && $stable(originRow)); // R5

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> !frameEnd); // R7

  AST_FRAME_LAST: assert property (@(posedge clk) disable iff (rst)
    frameEnd |-> windowValid && originRow == ROW_W'(ROWS - 1)
                 && originCol == COL_W'(IMG_W - WIN)); // R7

endmodule

bind colWinBuf colWinBuf_chk #(.WIN(WIN), .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .colValid   (colValid),
  .colData    (colData),
  .windowOut  (windowOut),
  .windowValid(windowValid),
  .originCol  (originCol),
  .originRow  (originRow),
  .frameEnd   (frameEnd)
);

// File: tb/colWinBuf_bench.sv
module colWinBuf_bench;

  localparam int N     = 4;
  localparam int W     = 8;
  localparam int H     = 6;
  localparam int ROWS  = H - N + 1;
  localparam int COL_W = $clog2(W);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COLB  = N * 8;
  localparam int TOTB  = N * COLB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic colValid = 1'b0;
  logic [COLB-1:0] colData = '0;
  logic [TOTB-1:0] windowOut;
  logic windowValid;
  logic [COL_W-1:0] originCol;
  logic [ROW_W-1:0] originRow;
  logic frameEnd;

  colWinBuf #(.WIN(N), .IMG_W(W), .IMG_H(H)) u_colWinBuf (
    .clk(clk), .rst(rst), .colValid(colValid), .colData(colData),
    .windowOut(windowOut), .windowValid(windowValid),
    .originCol(originCol), .originRow(originRow), .frameEnd(frameEnd)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model
  logic [TOTB-1:0] expWin = '0;
  int bc = 0;
  int br = 0;
  bit expValid = 0;
  int expOc = 0;
  int expOr = 0;
  bit expFe = 0;
  int seed = 1;

  function automatic logic [COLB-1:0] colPat(input int s);
    logic [COLB-1:0] v;
    for (int r = 0; r < N; r++) v[r*8 +: 8] = 8'((s * 37) + (r * 11) + 5);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(windowValid == expValid, req, "windowValid",
        $sformatf("%0d", windowValid), $sformatf("%0d", expValid));
    chk(int'(originCol) == expOc, req, "originCol",
        $sformatf("%0d", originCol), $sformatf("%0d", expOc));
    chk(int'(originRow) == expOr, req, "originRow",
        $sformatf("%0d", originRow), $sformatf("%0d", expOr));
    chk(frameEnd == expFe, req, "frameEnd",
        $sformatf("%0d", frameEnd), $sformatf("%0d", expFe));
    if (expValid)
      chk(windowOut == expWin, req, "windowOut",
          $sformatf("%h", windowOut), $sformatf("%h", expWin));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic driveCol(input string req);
    logic [COLB-1:0] d;
    d = colPat(seed);
    seed++;
    colValid = 1'b1;
    colData  = d;
    @(negedge clk);
    colValid = 1'b0;
    expWin   = {d, expWin[TOTB-1:COLB]};
    expValid = (bc >= N - 1);
    expOc    = expValid ? bc - (N - 1) : 0;
    expOr    = br;
    expFe    = (bc == W - 1) && (br == ROWS - 1);
    if (bc == W - 1) begin
      bc = 0;
      br = (br == ROWS - 1) ? 0 : br + 1;
    end else bc++;
    checkAll(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      colData = colPat(1000 + i);
      @(negedge clk);
      expFe = 0;
      checkAll(req);
    end
  endtask

  task automatic doReset(input string req);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    bc = 0; br = 0; expValid = 0; expOc = 0; expOr = 0; expFe = 0;
    checkAll(req);  // R1: outputs cleared
  endtask

  // R3: valid only after the N-th column, loads separated by gaps
  task automatic testFill();
    for (int i = 0; i < N; i++) begin
      driveCol("R3");
      idle(1, "R3");
    end
  endtask

  // R5: idle cycles with changing colData leave everything unchanged
  task automatic testHold();
    idle(4, "R5");
  endtask

  // R2/R4: rest of the row back-to-back, origin advances
  task automatic testSlide();
    for (int i = N; i < W; i++) driveCol("R4");
  endtask

  // R6: next row pass drops valid and moves the row origin down
  task automatic testRowWrap();
    driveCol("R6");
    for (int i = 1; i < W; i++) driveCol("R2");
  endtask

  // R7/R8: final row, frame pulse, then wrap to row 0
  task automatic testFrameEnd();
    for (int i = 0; i < W; i++) driveCol("R7");
    idle(2, "R7");
    driveCol("R8");
    for (int i = 1; i < N; i++) driveCol("R8");
  endtask

  // R1: reset in the middle of a row pass
  task automatic testMidReset();
    driveCol("R1");
    doReset("R1");
    for (int i = 0; i < N + 1; i++) driveCol("R1");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    doReset("R1");
    testFill();
    testHold();
    testSlide();
    testRowWrap();
    testFrameEnd();
    testMidReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule